// File: doc/BRIEF.md
# Timer Alarm and Trigger Event Unit

This block sits beside a free-running 64-bit nanosecond time counter and turns that time value into events. It holds two 64-bit alarm compare channels and two external trigger capture channels. It also keeps one sticky event register with a matching enable mask, which drives a single interrupt line. Three periodic pulse strobes from elsewhere in the timer also set event bits, so software sees every timer event in one place.

An alarm is armed by writing its low half and then its high half. It fires once, on the cycle in which the time input equals the programmed value. When it fires it sets its event bit and produces a one-cycle pulse on its output pin, whose polarity is selectable. Each trigger input passes through a two-stage synchronizer. On the selected edge, the time present on that cycle is latched into the channel's capture register and the channel's event bit is set. Software acknowledges events by writing ones to the event register.

Configuration and status use a plain write strobe and a combinational read port. No data stream crosses the block's edge, so no valid/ready handshake and no back-pressure apply. Every write is accepted on the cycle in which the strobe is high.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset every register reads zero, `irq` is low and both alarm outputs are low.
- R2: Event bits are sticky and are set by their sources. `pulse_in[0]`, `pulse_in[1]` and `pulse_in[2]` set bits 7, 6 and 5. Alarm 1 and alarm 2 set bits 16 and 17. Trigger 1 and trigger 2 set bits 24 and 25. All other bits read 0.
- R3: A write to the event register (address 1) clears each bit written as 1 and leaves bits written as 0 unchanged. When a source sets a bit in the same cycle as a write clears it, the bit stays set.
- R4: The mask register (address 2) keeps only the event bit positions. `irq` is high exactly when some event bit and its mask bit are both set.
- R5: Alarm 1 uses low/high halves at addresses 4/5 and alarm 2 uses addresses 6/7. Writing a low half disarms the channel and writing the high half arms it. An armed alarm fires when `time_now` equals its 64-bit value, and its event bit is set at that clock edge.
- R6: A fired alarm disarms itself. It does not fire again while the time stays equal, and a time that steps over the value without equalling it causes no fire.
- R7: Each firing gives a one-cycle pulse on `alarm_out`. Control bits 31 and 30 (address 0) invert the output of alarm 1 and alarm 2, where 0 means active high and 1 means active low.
- R8: Control bits 8 and 9 select the active edge of triggers 1 and 2, where 0 means rising and 1 means falling. The opposite edge is ignored. A change on `trig_in` before rising edge k is detected at edge k+2. At that edge the `time_now` present is captured into trigger 1 at addresses 8/9 or trigger 2 at addresses 10/11, with the low half first.
- R9: The control register keeps only bits 31, 30, 9 and 8. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time in nanoseconds |
| pulse_in | input | 3 | Periodic pulse strobes 1..3 |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| alarm_out | output | 2 | Alarm pulse outputs, polarity per control bits |
| irq | output | 1 | Interrupt, OR of masked events |

## Verification
The bench checks the collision between setting and clearing, because a design that gives the clear priority would lose a pulse that arrives during an acknowledge. Alarms are driven right up to equality, held there with the time frozen, and stepped past their value. A design using a greater-or-equal compare, or one that fails to disarm, would then fire late or fire repeatedly. Alarms are also rewritten through the low half only, which must leave them disarmed. Trigger captures are compared against the exact time value of the detection cycle, which catches a synchronizer that is one stage too short or too long. The ignored edge polarity checks that the edge-select bit is honoured. Constrained-random traffic on pulses, acknowledges and mask writes is compared against a bench model of the event and interrupt state.

// File: rtl/tmr_evt_pkg.sv
`timescale 1ns/1ps
package tmr_evt_pkg;
  localparam int AW    = 4;
  localparam int N_ALM = 2;
  localparam int N_TRG = 2;
  localparam int N_PP  = 3;

  // register word addresses
  localparam logic [AW-1:0] ADR_CTRL    = 4'd0;
  localparam logic [AW-1:0] ADR_EVT     = 4'd1;
  localparam logic [AW-1:0] ADR_MASK    = 4'd2;
  localparam logic [AW-1:0] ADR_ALM1_LO = 4'd4;
  localparam logic [AW-1:0] ADR_ALM1_HI = 4'd5;
  localparam logic [AW-1:0] ADR_ALM2_LO = 4'd6;
  localparam logic [AW-1:0] ADR_ALM2_HI = 4'd7;
  localparam logic [AW-1:0] ADR_CAP1_LO = 4'd8;
  localparam logic [AW-1:0] ADR_CAP1_HI = 4'd9;
  localparam logic [AW-1:0] ADR_CAP2_LO = 4'd10;
  localparam logic [AW-1:0] ADR_CAP2_HI = 4'd11;

  // event bit positions (shared by the mask)
  localparam int EB_TRG2 = 25;
  localparam int EB_TRG1 = 24;
  localparam int EB_ALM2 = 17;
  localparam int EB_ALM1 = 16;
  localparam int EB_PP1  = 7;   // PP2 = 6, PP3 = 5

  // control bit positions
  localparam int CB_ALM1_POL  = 31;
  localparam int CB_ALM2_POL  = 30;
  localparam int CB_TRG2_EDGE = 9;
  localparam int CB_TRG1_EDGE = 8;

  localparam logic [31:0] EVT_IMPL  = 32'h0303_00E0;
  localparam logic [31:0] CTRL_IMPL = 32'hC000_0300;
endpackage

// File: rtl/tmr_alarm_ch.sv
`timescale 1ns/1ps
module tmr_alarm_ch #(
  parameter int TW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          pol,
  output logic [TW-1:0] alm_val,
  output logic          fire,
  output logic          alm_out
);
  localparam int HW = TW - DW;

  logic [DW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          armed_q;
  logic          hit_q;

  assign alm_val = {hi_q, lo_q};
  assign fire    = armed_q && (time_now == alm_val);
  assign alm_out = hit_q ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= fire;
      if (fire)  armed_q <= 1'b0;
      if (wr_lo) begin
        lo_q    <= wr_data;
        armed_q <= 1'b0;
      end
      if (wr_hi) begin
        hi_q    <= wr_data[HW-1:0];
        armed_q <= 1'b1;
      end
    end
  end

  AST_FIRE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ($past(time_now) == $past(alm_val)));  // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !$past(wr_hi)) |-> !armed_q);  // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !$past(wr_hi)) |=> !hit_q);  // R7
endmodule

// File: rtl/tmr_trig_cap.sv
`timescale 1ns/1ps
module tmr_trig_cap #(
  parameter int TW   = 64,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic          fall_sel,
  input  logic [TW-1:0] time_now,
  output logic [TW-1:0] cap_q,
  output logic          cap_evt
);
  // sh[SYNC-1] is the synchronized level, sh[SYNC] its previous value
  logic [SYNC:0] sh;
  logic          rise, fall;

  assign rise    = sh[SYNC-1] & ~sh[SYNC];
  assign fall    = ~sh[SYNC-1] & sh[SYNC];
  assign cap_evt = fall_sel ? fall : rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      cap_q <= '0;
    end else begin
      sh <= {sh[SYNC-1:0], trig_in};
      if (cap_evt) cap_q <= time_now;
    end
  end

  AST_CAPTURE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(time_now)));  // R8
endmodule

// File: rtl/tmr_evt_reg.sv
`timescale 1ns/1ps
module tmr_evt_reg #(
  parameter int            DW   = 32,
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          evt_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  logic [DW-1:0] clr;

  assign clr = evt_wr ? wr_data : '0;
  assign irq = |(evt_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr) | set_vec) & IMPL;
      if (mask_wr) mask_q <= wr_data & IMPL;
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr |=> ((evt_q & $past(wr_data & ~set_vec & IMPL)) == '0));  // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));  // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((evt_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));  // R3
endmodule

// File: rtl/tmr_evt_unit.sv
`timescale 1ns/1ps
module tmr_evt_unit
  import tmr_evt_pkg::*;
#(
  parameter int TW   = 64,
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic [N_PP-1:0] pulse_in,
  input  logic [N_TRG-1:0] trig_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [N_ALM-1:0] alarm_out,
  output logic          irq
);
  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    evt_q, mask_q, set_vec;
  logic [TW-1:0]    alm_val [N_ALM];
  logic [TW-1:0]    cap_val [N_TRG];
  logic [N_ALM-1:0] alm_fire;
  logic [N_TRG-1:0] trg_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTRL)  ctrl_q <= wr_data & CTRL_IMPL;
  end

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    localparam logic [AW-1:0] LO_A = (i == 0) ? ADR_ALM1_LO : ADR_ALM2_LO;
    localparam logic [AW-1:0] HI_A = (i == 0) ? ADR_ALM1_HI : ADR_ALM2_HI;
    localparam int            PB   = (i == 0) ? CB_ALM1_POL : CB_ALM2_POL;
    tmr_alarm_ch #(.TW(TW), .DW(DW)) u_alm (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .wr_lo(wr_en && wr_addr == LO_A),
      .wr_hi(wr_en && wr_addr == HI_A),
      .wr_data(wr_data), .pol(ctrl_q[PB]),
      .alm_val(alm_val[i]), .fire(alm_fire[i]), .alm_out(alarm_out[i])
    );
  end

  for (genvar i = 0; i < N_TRG; i++) begin : g_trg
    localparam int EB = (i == 0) ? CB_TRG1_EDGE : CB_TRG2_EDGE;
    tmr_trig_cap #(.TW(TW), .SYNC(SYNC)) u_trg (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in[i]),
      .fall_sel(ctrl_q[EB]), .time_now(time_now),
      .cap_q(cap_val[i]), .cap_evt(trg_evt[i])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_PP; k++) set_vec[EB_PP1-k] = pulse_in[k];
    set_vec[EB_ALM1] = alm_fire[0];
    set_vec[EB_ALM2] = alm_fire[1];
    set_vec[EB_TRG1] = trg_evt[0];
    set_vec[EB_TRG2] = trg_evt[1];
  end

  tmr_evt_reg #(.DW(DW), .IMPL(EVT_IMPL)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .evt_wr(wr_en && wr_addr == ADR_EVT),
    .mask_wr(wr_en && wr_addr == ADR_MASK),
    .wr_data(wr_data), .evt_q(evt_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    case (rd_addr)
      ADR_CTRL:    rd_data = ctrl_q;
      ADR_EVT:     rd_data = evt_q;
      ADR_MASK:    rd_data = mask_q;
      ADR_ALM1_LO: rd_data = alm_val[0][DW-1:0];
      ADR_ALM1_HI: rd_data = DW'(alm_val[0][TW-1:DW]);
      ADR_ALM2_LO: rd_data = alm_val[1][DW-1:0];
      ADR_ALM2_HI: rd_data = DW'(alm_val[1][TW-1:DW]);
      ADR_CAP1_LO: rd_data = cap_val[0][DW-1:0];
      ADR_CAP1_HI: rd_data = DW'(cap_val[0][TW-1:DW]);
      ADR_CAP2_LO: rd_data = cap_val[1][DW-1:0];
      ADR_CAP2_HI: rd_data = DW'(cap_val[1][TW-1:DW]);
      default:     rd_data = '0;
    endcase
  end

  AST_CTRL_ONLY_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CTRL) |=> (ctrl_q == ($past(wr_data) & CTRL_IMPL)));  // R9
endmodule

// File: tb/tb_tmr_evt_unit.sv
`timescale 1ns/1ps
module tb_tmr_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic [2:0]  pulse_in = '0;
  logic [1:0]  trig_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  alarm_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] tstep = 64'd8;

  always #4 clk = ~clk;  // 125 MHz

  tmr_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .pulse_in(pulse_in),
    .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_out(alarm_out), .irq(irq)
  );

  function automatic logic [31:0] model_evt(logic [31:0] ev, logic [31:0] clr, logic [2:0] pp);
    logic [31:0] s = {24'h0, pp[0], pp[1], pp[2], 5'h0};
    return ((ev & ~clr) | s) & 32'h0303_00E0;
  endfunction

  function automatic logic model_irq(logic [31:0] ev, logic [31:0] mk);
    return |(ev & mk);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    time_now = time_now + tstep;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd64(logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, ev_m, mk_m;
    logic [63:0] r64, a_val, t_cap;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], r);
      chk("R1 reset register", {32'h0, r}, 64'h0);
    end
    chk("R1 reset irq", {63'h0, irq}, 64'h0);
    chk("R1 reset alarm_out", {62'h0, alarm_out}, 64'h0);

    // R9 control readback and unmapped read
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, r); chk("R9 ctrl implemented bits", {32'h0, r}, 64'hC000_0300);
    wr(4'd0, 32'h0);
    rd(4'd3, r); chk("R9 unmapped addr 3", {32'h0, r}, 64'h0);
    rd(4'd15, r); chk("R9 unmapped addr 15", {32'h0, r}, 64'h0);

    // R4 mask bits
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, r); chk("R4 mask implemented bits", {32'h0, r}, 64'h0303_00E0);

    // R2 pulse inputs
    pulse_in = 3'b001; cyc(); pulse_in = 3'b000;
    rd(4'd1, r); chk("R2 pulse1 -> bit7", {32'h0, r}, 64'h80);
    chk("R4 irq with mask", {63'h0, irq}, 64'h1);
    wr(4'd2, 32'h0);
    chk("R4 irq masked off", {63'h0, irq}, 64'h0);
    pulse_in = 3'b010; cyc(); pulse_in = 3'b000;
    rd(4'd1, r); chk("R2 pulse2 -> bit6 sticky", {32'h0, r}, 64'hC0);
    pulse_in = 3'b100; cyc(); pulse_in = 3'b000;
    rd(4'd1, r); chk("R2 pulse3 -> bit5", {32'h0, r}, 64'hE0);

    // R3 write-one-to-clear
    wr(4'd1, 32'h80);
    rd(4'd1, r); chk("R3 clear bit7 only", {32'h0, r}, 64'h60);
    wr(4'd1, 32'h0);
    rd(4'd1, r); chk("R3 zero write no effect", {32'h0, r}, 64'h60);
    pulse_in = 3'b001; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h80;
    cyc(); wr_en = 1'b0; pulse_in = 3'b000;
    rd(4'd1, r); chk("R3 set wins over clear", {32'h0, r}, 64'hE0);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, r); chk("R3 clear all", {32'h0, r}, 64'h0);

    // R2 R3 R4 constrained random
    ev_m = '0; mk_m = '0;
    for (int it = 0; it < 300; it++) begin
      logic [2:0]  pp = 3'($urandom_range(0, 7));
      logic        dw = ($urandom_range(0, 1) == 1);
      logic        dm = ($urandom_range(0, 3) == 0);
      logic [31:0] d  = $urandom;
      pulse_in = pp;
      wr_en = dw | dm; wr_addr = dw ? 4'd1 : 4'd2; wr_data = d;
      cyc();
      wr_en = 1'b0; pulse_in = '0;
      ev_m = model_evt(ev_m, dw ? d : 32'h0, pp);
      if (dm && !dw) mk_m = d & 32'h0303_00E0;
      rd(4'd1, r); chk("R3 random event reg", {32'h0, r}, {32'h0, ev_m});
      chk("R4 random irq", {63'h0, irq}, {63'h0, model_irq(ev_m, mk_m)});
    end
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0003_0000);

    // R5 R7 alarm 1 fires at equality
    a_val = time_now + 64'd80;
    wr(4'd4, a_val[31:0]);
    wr(4'd5, a_val[63:32]);
    rd64(4'd4, r64); chk("R5 alarm1 readback", r64, a_val);
    while (time_now != a_val) begin
      rd(4'd1, r); chk("R5 alarm1 not early", {63'h0, r[16]}, 64'h0);
      cyc();
    end
    cyc();
    rd(4'd1, r); chk("R5 alarm1 event bit16", {32'h0, r}, 64'h0001_0000);
    chk("R7 alarm1 pulse active high", {62'h0, alarm_out}, 64'h1);
    chk("R4 irq on alarm", {63'h0, irq}, 64'h1);
    cyc();
    chk("R7 alarm1 pulse one cycle", {62'h0, alarm_out}, 64'h0);

    // R6 no refire while time stays equal
    wr(4'd1, 32'h0001_0000);
    time_now = a_val; tstep = 64'd0;
    repeat (3) cyc();
    rd(4'd1, r); chk("R6 no refire at frozen time", {32'h0, r}, 64'h0);
    tstep = 64'd8;

    // R7 alarm 2 polarity, R6 time stepping over the value
    wr(4'd0, 32'h4000_0000);
    chk("R7 alarm2 idle level inverted", {62'h0, alarm_out}, 64'h2);
    a_val = time_now + 64'd80;
    wr(4'd6, a_val[31:0]);
    wr(4'd7, a_val[63:32]);
    while (time_now != a_val - 64'd8) cyc();
    time_now = a_val + 64'd8;
    repeat (3) cyc();
    rd(4'd1, r); chk("R6 skipped value no fire", {32'h0, r}, 64'h0);
    a_val = time_now + 64'd40;
    wr(4'd6, a_val[31:0]);
    wr(4'd7, a_val[63:32]);
    while (time_now != a_val) cyc();
    cyc();
    chk("R7 alarm2 active low pulse", {62'h0, alarm_out}, 64'h0);
    rd(4'd1, r); chk("R5 alarm2 event bit17", {32'h0, r}, 64'h0002_0000);
    cyc();
    chk("R7 alarm2 back to idle", {62'h0, alarm_out}, 64'h2);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0);

    // R5 low-half write alone leaves the alarm disarmed
    a_val = time_now + 64'd80;
    wr(4'd4, a_val[31:0]);
    wr(4'd5, a_val[63:32]);
    wr(4'd4, a_val[31:0]);
    repeat (14) cyc();
    rd(4'd1, r); chk("R5 low rewrite disarms", {32'h0, r}, 64'h0);

    // R8 trigger 1 rising
    trig_in[0] = 1'b1; t_cap = time_now;
    cyc(); cyc();
    rd(4'd1, r); chk("R8 trig1 not before sync", {32'h0, r}, 64'h0);
    cyc();
    rd(4'd1, r); chk("R8 trig1 rising event bit24", {32'h0, r}, 64'h0100_0000);
    rd64(4'd8, r64); chk("R8 trig1 captured time", r64, t_cap + 64'd16);
    wr(4'd1, 32'hFFFF_FFFF);

    // R8 trigger 1 falling selected
    wr(4'd0, 32'h0000_0100);
    trig_in[0] = 1'b0; t_cap = time_now;
    repeat (3) cyc();
    rd(4'd1, r); chk("R8 trig1 falling event", {32'h0, r}, 64'h0100_0000);
    rd64(4'd8, r64); chk("R8 trig1 falling capture", r64, t_cap + 64'd16);
    wr(4'd1, 32'hFFFF_FFFF);
    trig_in[0] = 1'b1;
    repeat (5) cyc();
    rd(4'd1, r); chk("R8 trig1 rising ignored event", {32'h0, r}, 64'h0);
    rd64(4'd8, r64); chk("R8 trig1 rising ignored capture", r64, t_cap + 64'd16);

    // R8 trigger 2 rising
    trig_in[1] = 1'b1; t_cap = time_now;
    repeat (3) cyc();
    rd(4'd1, r); chk("R8 trig2 event bit25", {32'h0, r}, 64'h0200_0000);
    rd64(4'd10, r64); chk("R8 trig2 captured time", r64, t_cap + 64'd16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule